// File: doc/BRIEF.md
# Byte-Lane Split Bus Unit

This block sits between a byte-addressed requester and an external data bus that is two bytes wide and selects its lanes with byte enables. The requester asks for either one byte or a two-byte little-endian word at any byte address, to read or to write. The unit turns each request into one or two bus cycles and drives the lane selects for each. It puts the returned bytes back together. The requester waits on a busy flag until a one-cycle completion pulse arrives.

Two signals select the lanes: address bit 0 and an active-low upper-lane enable. With both low, the cycle uses the whole bus. With the upper enable low and address bit 0 high, it uses only the upper lane. With the upper enable high and address bit 0 low, it uses only the lower lane. The fourth combination is never driven. A word at an odd address becomes two lane cycles: the upper lane of the lower word, then the lower lane of the next word. The requester never sees the split.

Top module: `lane_split_bus_unit`

## Requirements
- R1: After a synchronous active-low reset, req_ready is 1, and req_busy, req_done and bus_cyc are 0.
- R2: A word request at an even address uses exactly one bus cycle at that address, with bus_hi_n=0 and bus_addr[0]=0. On a read, req_rdata equals the full bus word, bits 15:8 coming from the higher byte address.
- R3: A byte request at an even address uses one bus cycle with bus_hi_n=1 and bus_addr[0]=0. A read returns bus_rdata[7:0] in req_rdata[7:0], with req_rdata[15:8]=0.
- R4: A byte request at an odd address uses one bus cycle with bus_hi_n=0 and bus_addr[0]=1. A read returns bus_rdata[15:8] in req_rdata[7:0], with req_rdata[15:8]=0.
- R5: While bus_cyc is 1, bus_hi_n=1 together with bus_addr[0]=1 never occurs.
- R6: A word request at an odd address A uses exactly two bus cycles. The first is at A with bus_hi_n=0, and its upper lane carries the low byte. The second is at A+1 with bus_hi_n=1, and its lower lane carries the high byte. A read returns {high, low}.
- R7: On writes, the enabled lanes carry the request's bytes in the order of R2 to R6. In a single-lane cycle, the other lane carries a copy of the same byte. Bytes outside the request keep their values.
- R8: Once a bus cycle starts, bus_addr, bus_hi_n, bus_we and bus_wdata stay stable until the cycle in which bus_ack is 1.
- R9: req_busy is 1 from the cycle after acceptance until completion, including between the two halves of a split access. req_done pulses for exactly one cycle, the cycle after the final bus_ack.
- R10: A request is accepted only when req_ready is 1. req_valid raised while busy and dropped before the unit is idle produces no bus cycle and no completion.
- R11: A word at the highest odd address wraps: its second cycle is at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = two-byte word, 0 = single byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 2*LANE_W | Write data, low byte in bits 7:0 |
| req_ready | output | 1 | Unit idle; a request is taken this cycle |
| req_busy | output | 1 | Access in progress |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 2*LANE_W | Read result, valid with req_done |
| bus_cyc | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Byte address of the bus cycle; bit 0 takes part in lane selection |
| bus_hi_n | output | 1 | Active-low upper-lane enable |
| bus_wdata | output | 2*LANE_W | Write data on both lanes |
| bus_rdata | input | 2*LANE_W | Read data from the bus |
| bus_ack | input | 1 | Bus cycle completes on this edge |

## Verification
The properties assume that bus_ack is high only while bus_cyc is high, and for one cycle per bus cycle. They also assume that the requester keeps its request fields steady in the cycle it raises req_valid. The bench's bus model follows this: it inserts zero to two wait states before each single-cycle acknowledge. The requester model changes inputs only on the falling edge and raises req_valid while busy only in the deliberate R10 probe.

// File: rtl/lane_split_pkg.sv
// Shared types for the byte-lane split bus unit.
// Assumes a bus of exactly two byte lanes.
package lane_split_pkg;

    // Access sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PH1  = 2'd1,
        ST_PH2  = 2'd2,
        ST_FIN  = 2'd3
    } phase_e;

    // Lane selection for one bus cycle
    typedef struct packed {
        logic a0;     // address bit 0 driven on the bus
        logic hi_n;   // active-low upper-lane enable
        logic split;  // access needs a second cycle
    } lane_sel_t;

endpackage

// File: rtl/lane_plan.sv
// Lane planner: from the request's address bit 0, its size and the
// current phase, works out the lane selects for this bus cycle.
// Assumes the second phase only occurs for odd-address words.
module lane_plan
    import lane_split_pkg::*;
(
    input  logic      addr_lsb,
    input  logic      is_word,
    input  logic      second,
    output lane_sel_t sel
);

    // Select lanes for the current phase
    always_comb begin
        if (second) begin
            sel.a0    = 1'b0;
            sel.hi_n  = 1'b1;
            sel.split = 1'b1;
        end else if (is_word) begin
            sel.a0    = addr_lsb;
            sel.hi_n  = 1'b0;
            sel.split = addr_lsb;
        end else begin
            sel.a0    = addr_lsb;
            sel.hi_n  = ~addr_lsb;
            sel.split = 1'b0;
        end
    end

endmodule

// File: rtl/write_steer.sv
// Write steering: places request bytes onto the bus lanes. A full aligned
// word passes straight through. Otherwise the single byte of this phase is
// copied onto every lane, so the unused lane is driven but not enabled.
module write_steer #(
    parameter int LANE_W = 8
) (
    input  logic [2*LANE_W-1:0] wdata,
    input  logic                full_word,
    input  logic                second,
    output logic [2*LANE_W-1:0] bus_wdata
);

    localparam int LANES = 2;

    logic [LANE_W-1:0] phase_byte;

    // Pick the byte that this phase moves
    always_comb begin
        phase_byte = second ? wdata[LANE_W +: LANE_W] : wdata[0 +: LANE_W];
    end

    // Drive each lane either from its own byte or from the phase byte
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bus_wdata[g*LANE_W +: LANE_W] =
            full_word ? wdata[g*LANE_W +: LANE_W] : phase_byte;
    end

endmodule

// File: rtl/read_merge.sv
// Read merge: assembles the requester's little-endian result from the lanes
// of the current bus cycle and, in the second phase, the low byte held
// from the first.
module read_merge #(
    parameter int LANE_W = 8
) (
    input  logic [2*LANE_W-1:0] bus_rdata,
    input  logic                a0,
    input  logic                hi_n,
    input  logic                second,
    input  logic [LANE_W-1:0]   low_hold,
    output logic [2*LANE_W-1:0] merged
);

    localparam logic [LANE_W-1:0] ZERO_B = '0;

    // Combine lanes according to the enables of this cycle
    always_comb begin
        if (second)
            merged = {bus_rdata[0 +: LANE_W], low_hold};
        else if (!hi_n && !a0)
            merged = bus_rdata;
        else if (a0)
            merged = {ZERO_B, bus_rdata[LANE_W +: LANE_W]};
        else
            merged = {ZERO_B, bus_rdata[0 +: LANE_W]};
    end

endmodule

// File: rtl/lane_split_bus_unit.sv
// Byte-lane split bus unit (top). Accepts byte or word requests at any
// byte address when idle, runs one bus cycle, or two for an odd-address
// word, and pulses req_done one cycle after the last acknowledge.
// Assumes bus_ack is a single-cycle pulse given only during bus_cyc.
module lane_split_bus_unit
    import lane_split_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_word,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*LANE_W-1:0] req_wdata,
    output logic                req_ready,
    output logic                req_busy,
    output logic                req_done,
    output logic [2*LANE_W-1:0] req_rdata,
    output logic                bus_cyc,
    output logic                bus_we,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_hi_n,
    output logic [2*LANE_W-1:0] bus_wdata,
    input  logic [2*LANE_W-1:0] bus_rdata,
    input  logic                bus_ack
);

    localparam int                DATA_W = 2 * LANE_W;
    localparam logic [ADDR_W-1:0] ONE_A  = {{(ADDR_W-1){1'b0}}, 1'b1};

    phase_e            st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q, word_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, merged;
    logic [LANE_W-1:0] low_q;
    logic              second, take, split_ack, fin_ack;
    lane_sel_t         sel;

    assign take      = req_valid && (st_q == ST_IDLE);
    assign second    = (st_q == ST_PH2);
    assign split_ack = (st_q == ST_PH1) && bus_ack && sel.split;
    assign fin_ack   = bus_cyc && bus_ack && !split_ack;

    lane_plan u_plan (
        .addr_lsb (addr_q[0]),
        .is_word  (word_q),
        .second   (second),
        .sel      (sel)
    );

    write_steer #(.LANE_W(LANE_W)) u_steer (
        .wdata     (wdata_q),
        .full_word (word_q && !addr_q[0]),
        .second    (second),
        .bus_wdata (bus_wdata)
    );

    read_merge #(.LANE_W(LANE_W)) u_merge (
        .bus_rdata (bus_rdata),
        .a0        (sel.a0),
        .hi_n      (sel.hi_n),
        .second    (second),
        .low_hold  (low_q),
        .merged    (merged)
    );

    // Next-state sequencing of the access phases
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (take)    st_d = ST_PH1;
            ST_PH1:  if (bus_ack) st_d = sel.split ? ST_PH2 : ST_FIN;
            ST_PH2:  if (bus_ack) st_d = ST_FIN;
            default:              st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Capture request fields on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            word_q  <= 1'b0;
            wdata_q <= '0;
        end else if (take) begin
            addr_q  <= req_addr;
            we_q    <= req_write;
            word_q  <= req_word;
            wdata_q <= req_wdata;
        end
    end

    // Hold the low byte delivered by the first half of a split read
    always_ff @(posedge clk) begin
        if (!rst_n)         low_q <= '0;
        else if (split_ack) low_q <= merged[0 +: LANE_W];
    end

    // Register the assembled result on the final acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (fin_ack) rdata_q <= merged;
    end

    assign req_ready = (st_q == ST_IDLE);
    assign req_busy  = (st_q != ST_IDLE);
    assign req_done  = (st_q == ST_FIN);
    assign req_rdata = rdata_q;
    assign bus_cyc   = (st_q == ST_PH1) || (st_q == ST_PH2);
    assign bus_we    = we_q;
    assign bus_addr  = second ? (addr_q + ONE_A) : addr_q;
    assign bus_hi_n  = sel.hi_n;

    // R5: the both-lanes-off encoding never appears on an active cycle
    a_r5_no_dead_code: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> !(bus_hi_n && bus_addr[0]));

    // R6: the second half is an even address on the lower lane only
    a_r6_second_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PH2) |-> (!bus_addr[0] && bus_hi_n));

    // R8: bus cycle signals hold steady until acknowledged
    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ack) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_hi_n)
                                   && $stable(bus_we) && $stable(bus_wdata)));

    // R9: busy stays up between the two halves of a split access
    a_r9_busy_spans_split: assert property (@(posedge clk) disable iff (!rst_n)
        split_ack |=> (req_busy && bus_cyc && !req_done));

    // R9: completion follows the final acknowledge by one cycle
    a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        fin_ack |=> req_done);

    // R9: completion is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    // R10: captured request is untouched while an access is in flight
    a_r10_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_busy |=> ($stable(addr_q) && $stable(word_q) && $stable(we_q)));

endmodule

// File: tb/lane_split_bus_unit_tb.sv
`timescale 1ns/1ps
module lane_split_bus_unit_tb;

    localparam int AW = 8;
    localparam int LW = 8;
    localparam int DW = 2 * LW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, req_busy, req_done;
    logic [DW-1:0] req_rdata;
    logic          bus_cyc, bus_we, bus_hi_n;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = 16'hDEAD;
    logic          bus_ack = 1'b0;

    lane_split_bus_unit #(.ADDR_W(AW), .LANE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_busy(req_busy), .req_done(req_done),
        .req_rdata(req_rdata),
        .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_hi_n(bus_hi_n), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    logic [15:0] mem [0:127];
    logic [7:0]  sh  [0:255];

    typedef struct {
        bit          is_rd;
        logic [15:0] data;
        int          ncyc;
        logic [7:0]  a1, a2;
        logic [1:0]  e1, e2;   // {hi_n, addr bit 0}
        string       rq;
    } exp_t;

    exp_t exp_q[$];

    // Bus model and completion monitor in one falling-edge process
    int          ack_cnt = 0;
    int          wait_n = 0;
    logic [7:0]  la [0:1];
    logic [1:0]  le [0:1];
    bit          hold_v = 0, busy_bad = 0, prev_done = 0;
    logic [7:0]  h_addr;
    logic        h_hi, h_we;
    logic [15:0] h_wd;

    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0; ack_cnt = 0; hold_v = 0; wait_n = 0;
            prev_done = 0; busy_bad = 0;
        end else begin
            if ((bus_cyc || ack_cnt > 0) && !req_busy) busy_bad = 1;
            if (req_done) begin
                chk(!prev_done, "R9", "done pulse width", 32'(prev_done), 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R10", "unexpected completion", 1, 0);
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    chk(ack_cnt == it.ncyc, it.rq, "bus cycle count", ack_cnt, it.ncyc);
                    chk(la[0] == it.a1, it.rq, "first cycle address", la[0], it.a1);
                    chk(le[0] == it.e1, it.rq, "first cycle lanes", le[0], it.e1);
                    if (it.ncyc == 2) begin
                        chk(la[1] == it.a2, it.rq, "second cycle address", la[1], it.a2);
                        chk(le[1] == it.e2, it.rq, "second cycle lanes", le[1], it.e2);
                    end
                    if (it.is_rd)
                        chk(req_rdata == it.data, it.rq, "read data", req_rdata, it.data);
                    chk(!busy_bad, "R9", "busy dropped mid access", 32'(busy_bad), 0);
                end
                ack_cnt = 0;
                busy_bad = 0;
            end
            prev_done = req_done;

            if (bus_ack) begin
                bus_ack = 1'b0;
                bus_rdata = 16'hDEAD;
                hold_v = 0;
                wait_n = $urandom_range(0, 2);
            end else if (bus_cyc) begin
                if (!hold_v) begin
                    hold_v = 1; h_addr = bus_addr; h_hi = bus_hi_n;
                    h_we = bus_we; h_wd = bus_wdata;
                end else if (bus_addr != h_addr || bus_hi_n != h_hi ||
                             bus_we != h_we || bus_wdata != h_wd) begin
                    chk(0, "R8", "bus cycle changed before ack", bus_addr, h_addr);
                end
                if (wait_n == 0) begin
                    chk(!(bus_hi_n && bus_addr[0]), "R5", "lane encoding",
                        {bus_hi_n, bus_addr[0]}, 0);
                    if (bus_we) begin
                        if (bus_hi_n || bus_addr[0])
                            chk(bus_wdata[15:8] == bus_wdata[7:0], "R7",
                                "unused lane copy", bus_wdata[15:8], bus_wdata[7:0]);
                        if (!bus_hi_n) mem[bus_addr[7:1]][15:8] = bus_wdata[15:8];
                        if (!bus_addr[0]) mem[bus_addr[7:1]][7:0] = bus_wdata[7:0];
                    end
                    if (ack_cnt < 2) begin
                        la[ack_cnt] = bus_addr;
                        le[ack_cnt] = {bus_hi_n, bus_addr[0]};
                    end
                    ack_cnt++;
                    bus_rdata = mem[bus_addr[7:1]];
                    bus_ack = 1'b1;
                end else begin
                    wait_n--;
                end
            end
        end
    end

    // Driver: push the expected outcome, present the request, wait for it
    task automatic issue(input bit we, input bit wd, input logic [7:0] a,
                         input logic [15:0] wv, input string rq, input bit poke);
        exp_t it;
        logic [7:0] ap;
        ap = a + 8'd1;
        it.is_rd = !we;
        it.rq = rq;
        it.a1 = a;
        it.a2 = ap;
        it.e2 = 2'b10;
        it.ncyc = (wd && a[0]) ? 2 : 1;
        if (wd) it.e1 = a[0] ? 2'b01 : 2'b00;
        else    it.e1 = a[0] ? 2'b01 : 2'b10;
        it.data = wd ? {sh[ap], sh[a]} : {8'h00, sh[a]};
        if (we) begin
            sh[a] = wv[7:0];
            if (wd) sh[ap] = wv[15:8];
        end
        while (!req_ready) @(negedge clk);
        exp_q.push_back(it);
        req_valid = 1'b1; req_write = we; req_word = wd;
        req_addr = a; req_wdata = wv;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_valid = 1'b1; req_word = 1'b1; req_addr = a ^ 8'h40;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i] = 16'(i * 16'h0713 + 16'h2C5B);
            sh[2*i]   = mem[i][7:0];
            sh[2*i+1] = mem[i][15:8];
        end
        repeat (4) @(negedge clk);
        // R1: state held in reset
        chk(req_ready && !req_busy && !req_done && !bus_cyc, "R1", "in reset",
            {req_ready, req_busy, req_done, bus_cyc}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !req_busy && !req_done && !bus_cyc, "R1", "after reset",
            {req_ready, req_busy, req_done, bus_cyc}, 4'b1000);

        issue(0, 1, 8'h10, 0, "R2", 0);     // aligned word read
        issue(0, 0, 8'h22, 0, "R3", 0);     // even byte read
        issue(0, 0, 8'h23, 0, "R4", 0);     // odd byte read
        issue(0, 1, 8'h31, 0, "R6", 0);     // split word read
        issue(0, 1, 8'hFF, 0, "R11", 0);    // wrap to address 0

        issue(1, 0, 8'h40, 16'h77A5, "R7", 0);
        issue(1, 0, 8'h43, 16'h665A, "R7", 0);
        issue(1, 1, 8'h44, 16'h1234, "R7", 0);
        issue(1, 1, 8'h47, 16'hBEEF, "R7", 0);
        for (int k = 0; k < 5; k++) issue(0, 1, 8'(8'h40 + 2*k), 0, "R7", 0);

        // R10: request raised while busy must leave no trace
        issue(0, 1, 8'h55, 0, "R10", 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!bus_cyc && !req_done, "R10", "no extra bus activity",
                {bus_cyc, req_done}, 0);
        end

        issue(1, 1, 8'hFF, 16'hC3E1, "R11", 0);
        issue(0, 1, 8'hFF, 0, "R11", 0);
        issue(0, 0, 8'h00, 0, "R11", 0);

        // R8: random mix under random wait states
        for (int n = 0; n < 300; n++) begin
            bit we, wd;
            logic [7:0] a;
            we = 1'($urandom_range(0, 1));
            wd = 1'($urandom_range(0, 1));
            a  = 8'($urandom_range(0, 255));
            issue(we, wd, a, 16'($urandom), "R8", 0);
        end

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule